// File: doc/BRIEF.md
# Fixed-Ratio PLL Dividers with Lock and Test Pin Selector

This block holds the digital dividers of a fixed-frequency synthesizer loop and the steering logic for one shared lock/test pin. Running on the crystal clock, it produces two reference ticks: one at the crystal rate divided by 130 for the fixed loop, and one at the crystal rate divided by 4 for the tunable loop. It also counts oscillator feedback events and emits a tick every N of them. N is normally 1034. Two alternative values, 987 and 1081, are available to shift the fixed oscillator for test.

A 7-bit test code does two jobs. It chooses the feedback ratio, and it chooses what drives the pin. The pin can carry one of the loop lock flags, their AND, or a scaled copy of one divider's output. The lock flags and the tunable loop's programmable divider pulses come from logic outside this block. A new feedback ratio is taken up only when the feedback counter wraps. The interval already in progress therefore always finishes at the old ratio.

Top module: `pll_fixdiv_testsel`

## Requirements
- R1: `ref2_tick` is high for one clock in every 130 clocks.
- R2: `ref1_tick` is high for one clock in every 4 clocks.
- R3: With code 0000000, `fb_tick` pulses for one clock after every 1034th clock in which `fb_event` is high.
- R4: Code 1000000 sets the feedback ratio to 987 and code 1100000 sets it to 1081. Every other code uses 1034.
- R5: A ratio change takes effect at the feedback counter's next wrap. The interval in progress completes at the previous ratio.
- R6: Code 0000000 puts `lock_a` (the tunable loop lock) on `test_pin`. Any code not listed in R7 to R10 behaves the same way, so `lock_b` has no effect on the pin under these codes.
- R7: Code 0000100 puts `lock_b` (the fixed loop lock) on the pin. Code 0000001 puts `lock_a AND lock_b` on the pin.
- R8: Code 0010010 puts the `prog_pulse` stream divided by 16 on the pin. The pin toggles once every 8 pulses.
- R9: Code 0011010 puts `ref1_tick` divided by 8 on the pin. With the divide-by-4 reference, this gives a 32-clock period.
- R10: Code 0010110 puts the feedback ticks divided by 2 on the pin, giving a period of twice the ratio. Code 0011110 puts `ref2_tick` on the pin undivided, with a 130-clock period.
- R11: `test_pin` is registered. It follows its selected source one clock later. While reset is held, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_code | input | 7 | Pin source and feedback ratio code |
| lock_a | input | 1 | Tunable loop lock flag |
| lock_b | input | 1 | Fixed loop lock flag |
| fb_event | input | 1 | Oscillator feedback event, one per clock at most |
| prog_pulse | input | 1 | Tunable loop programmable divider output pulse |
| ref1_tick | output | 1 | Crystal divided by 4 |
| ref2_tick | output | 1 | Crystal divided by 130 |
| fb_tick | output | 1 | Feedback divider wrap pulse |
| test_pin | output | 1 | Lock flag or scaled test signal |

## Verification
Each divider tick appears one clock after the counter state that ends its interval. A lock flag reaches the pin one clock after it changes. A scaled signal passes through the scaler flop and then the pin flop, so it arrives two clocks after its source. All signals are sampled on the falling clock edge. Level checks wait three clocks after a stimulus before sampling. Period checks skip the first rising edge after a mode change and measure the clock count between the next two rising edges. For the ratio-change case, the count starts at a rising edge of `fb_tick`, and the code is switched right after that edge.

// File: rtl/pll_fixdiv_pkg.sv
package pll_fixdiv_pkg;

  localparam int CODE_W = 7;

  localparam logic [CODE_W-1:0] CODE_LOCK_A   = 7'b0000000;
  localparam logic [CODE_W-1:0] CODE_LOCK_B   = 7'b0000100;
  localparam logic [CODE_W-1:0] CODE_LOCK_AB  = 7'b0000001;
  localparam logic [CODE_W-1:0] CODE_PROG_16  = 7'b0010010;
  localparam logic [CODE_W-1:0] CODE_REF1_8   = 7'b0011010;
  localparam logic [CODE_W-1:0] CODE_FB_2     = 7'b0010110;
  localparam logic [CODE_W-1:0] CODE_REF2_1   = 7'b0011110;
  localparam logic [CODE_W-1:0] CODE_FB_LOW   = 7'b1000000;
  localparam logic [CODE_W-1:0] CODE_FB_HIGH  = 7'b1100000;

  typedef enum logic [2:0] {
    SRC_LOCK_A,
    SRC_LOCK_B,
    SRC_LOCK_AB,
    SRC_PROG,
    SRC_REF1,
    SRC_FB,
    SRC_REF2
  } pin_src_e;

  typedef enum logic [1:0] {
    FBR_NOMINAL,
    FBR_LOW,
    FBR_HIGH
  } fb_ratio_e;

  // Scaled test paths, in the index order used by the scaler bank.
  localparam int N_SCALED = 4;
  localparam int IDX_PROG = 0;
  localparam int IDX_REF1 = 1;
  localparam int IDX_FB   = 2;
  localparam int IDX_REF2 = 3;

  function automatic pin_src_e decode_src(input logic [CODE_W-1:0] code);
    pin_src_e s;
    case (code)
      CODE_LOCK_B:  s = SRC_LOCK_B;
      CODE_LOCK_AB: s = SRC_LOCK_AB;
      CODE_PROG_16: s = SRC_PROG;
      CODE_REF1_8:  s = SRC_REF1;
      CODE_FB_2:    s = SRC_FB;
      CODE_REF2_1:  s = SRC_REF2;
      default:      s = SRC_LOCK_A;
    endcase
    return s;
  endfunction

  function automatic fb_ratio_e decode_ratio(input logic [CODE_W-1:0] code);
    fb_ratio_e r;
    case (code)
      CODE_FB_LOW:  r = FBR_LOW;
      CODE_FB_HIGH: r = FBR_HIGH;
      default:      r = FBR_NOMINAL;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fixdiv_rst_sync.sv
module fixdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/fixdiv_counter.sv
// Modulo counter with a terminal pulse. The ratio in use is latched only at wrap.
module fixdiv_counter #(
  parameter int CNT_W = 11,
  parameter int INIT  = 130
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] ratio_next,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ratio_q, ratio_d;
  logic             tick_q, tick_d;
  logic             at_end;

  always_comb begin
    at_end  = (cnt_q >= (ratio_q - CNT_W'(1)));
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    tick_d  = 1'b0;
    if (cnt_en) begin
      if (at_end) begin
        cnt_d   = '0;
        ratio_d = ratio_next;
        tick_d  = 1'b1;
      end else begin
        cnt_d   = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= CNT_W'(INIT);
      tick_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      tick_q  <= tick_d;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/fixdiv_scaler.sv
// Turns a pulse stream into a square wave with period SCALE pulses.
// SCALE of 1 re-times the pulse without dividing.
module fixdiv_scaler #(
  parameter int SCALE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic wave
);
  localparam int HALF = (SCALE > 1) ? SCALE / 2 : 1;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

  generate
    if (SCALE <= 1) begin : g_pass
      logic pass_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pass_q <= 1'b0;
        else        pass_q <= pulse;
      end
      assign wave = pass_q;
    end else begin : g_div
      logic [HW-1:0] cnt_q, cnt_d;
      logic          tog_q, tog_d;

      always_comb begin
        cnt_d = cnt_q;
        tog_d = tog_q;
        if (pulse) begin
          if (cnt_q == HW'(HALF - 1)) begin
            cnt_d = '0;
            tog_d = ~tog_q;
          end else begin
            cnt_d = cnt_q + HW'(1);
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          tog_q <= 1'b0;
        end else begin
          cnt_q <= cnt_d;
          tog_q <= tog_d;
        end
      end
      assign wave = tog_q;
    end
  endgenerate
endmodule

// File: rtl/pll_fixdiv_testsel.sv
module pll_fixdiv_testsel
  import pll_fixdiv_pkg::*;
#(
  parameter int REF1_DIV     = 4,
  parameter int REF2_DIV     = 130,
  parameter int FB_DIV_NOM   = 1034,
  parameter int FB_DIV_LOW   = 987,
  parameter int FB_DIV_HIGH  = 1081,
  parameter int PROG_SCALE   = 16,
  parameter int REF1_SCALE   = 8,
  parameter int FB_SCALE     = 2,
  parameter int REF2_SCALE   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] test_code,
  input  logic              lock_a,
  input  logic              lock_b,
  input  logic              fb_event,
  input  logic              prog_pulse,
  output logic              ref1_tick,
  output logic              ref2_tick,
  output logic              fb_tick,
  output logic              test_pin
);
  localparam int FB_MAX_A = (FB_DIV_NOM > FB_DIV_LOW) ? FB_DIV_NOM : FB_DIV_LOW;
  localparam int FB_MAX   = (FB_MAX_A > FB_DIV_HIGH) ? FB_MAX_A : FB_DIV_HIGH;
  localparam int DIV_MAX  = (FB_MAX > REF2_DIV) ? FB_MAX : REF2_DIV;
  localparam int CNT_W    = $clog2(DIV_MAX + 1);
  localparam int SCALES [N_SCALED] = '{PROG_SCALE, REF1_SCALE, FB_SCALE, REF2_SCALE};

  logic                rst_sync_n;
  logic [CNT_W-1:0]    fb_ratio_next;
  logic [N_SCALED-1:0] scale_in;
  logic [N_SCALED-1:0] scale_out;
  pin_src_e            src_sel;
  logic                pin_d, pin_q;

  fixdiv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fixdiv_counter #(.CNT_W(CNT_W), .INIT(REF1_DIV)) u_ref1_div (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cnt_en     (1'b1),
    .ratio_next (CNT_W'(REF1_DIV)),
    .tick       (ref1_tick)
  );

  fixdiv_counter #(.CNT_W(CNT_W), .INIT(REF2_DIV)) u_ref2_div (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cnt_en     (1'b1),
    .ratio_next (CNT_W'(REF2_DIV)),
    .tick       (ref2_tick)
  );

  always_comb begin
    case (decode_ratio(test_code))
      FBR_LOW:  fb_ratio_next = CNT_W'(FB_DIV_LOW);
      FBR_HIGH: fb_ratio_next = CNT_W'(FB_DIV_HIGH);
      default:  fb_ratio_next = CNT_W'(FB_DIV_NOM);
    endcase
  end

  fixdiv_counter #(.CNT_W(CNT_W), .INIT(FB_DIV_NOM)) u_fb_div (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cnt_en     (fb_event),
    .ratio_next (fb_ratio_next),
    .tick       (fb_tick)
  );

  always_comb begin
    scale_in           = '0;
    scale_in[IDX_PROG] = prog_pulse;
    scale_in[IDX_REF1] = ref1_tick;
    scale_in[IDX_FB]   = fb_tick;
    scale_in[IDX_REF2] = ref2_tick;
  end

  for (genvar g = 0; g < N_SCALED; g++) begin : g_scale
    fixdiv_scaler #(.SCALE(SCALES[g])) u_scaler (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .pulse (scale_in[g]),
      .wave  (scale_out[g])
    );
  end

  always_comb begin
    src_sel = decode_src(test_code);
    case (src_sel)
      SRC_LOCK_B:  pin_d = lock_b;
      SRC_LOCK_AB: pin_d = lock_a & lock_b;
      SRC_PROG:    pin_d = scale_out[IDX_PROG];
      SRC_REF1:    pin_d = scale_out[IDX_REF1];
      SRC_FB:      pin_d = scale_out[IDX_FB];
      SRC_REF2:    pin_d = scale_out[IDX_REF2];
      default:     pin_d = lock_a;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pin_q <= 1'b0;
    else             pin_q <= pin_d;
  end

  assign test_pin = pin_q;
endmodule

// File: rtl/pll_fixdiv_testsel_chk.sv
module pll_fixdiv_testsel_chk
  import pll_fixdiv_pkg::*;
#(
  parameter int REF1_DIV    = 4,
  parameter int REF2_DIV    = 130,
  parameter int FB_DIV_NOM  = 1034,
  parameter int FB_DIV_LOW  = 987,
  parameter int FB_DIV_HIGH = 1081
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] test_code,
  input logic              lock_a,
  input logic              lock_b,
  input logic              fb_event,
  input logic              ref1_tick,
  input logic              ref2_tick,
  input logic              fb_tick,
  input logic              test_pin
);
  int   gap1, gap2, fb_cnt;
  logic seen1, seen2, seen_fb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap1 <= 0; gap2 <= 0; fb_cnt <= 0;
      seen1 <= 1'b0; seen2 <= 1'b0; seen_fb <= 1'b0;
    end else begin
      gap1 <= ref1_tick ? 1 : gap1 + 1;
      gap2 <= ref2_tick ? 1 : gap2 + 1;
      if (fb_tick)       fb_cnt <= fb_event ? 1 : 0;
      else if (fb_event) fb_cnt <= fb_cnt + 1;
      if (ref1_tick) seen1 <= 1'b1;
      if (ref2_tick) seen2 <= 1'b1;
      if (fb_tick)   seen_fb <= 1'b1;
    end
  end

  AST_REF2_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (ref2_tick && seen2) |-> (gap2 == REF2_DIV)); // R1
  AST_REF1_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (ref1_tick && seen1) |-> (gap1 == REF1_DIV)); // R2
  AST_FB_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tick |=> !fb_tick); // R3
  AST_FB_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_tick && seen_fb) |-> (fb_cnt == FB_DIV_NOM || fb_cnt == FB_DIV_LOW || fb_cnt == FB_DIV_HIGH)); // R4
  AST_PIN_LOCK_A: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == CODE_LOCK_A) |=> (test_pin == $past(lock_a))); // R6
  AST_PIN_LOCK_B: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == CODE_LOCK_B) |=> (test_pin == $past(lock_b))); // R7
  AST_PIN_LOCK_AB: assert property (@(posedge clk) disable iff (!rst_n)
    (test_code == CODE_LOCK_AB) |=> (test_pin == $past(lock_a && lock_b))); // R7
endmodule

bind pll_fixdiv_testsel pll_fixdiv_testsel_chk #(
  .REF1_DIV    (REF1_DIV),
  .REF2_DIV    (REF2_DIV),
  .FB_DIV_NOM  (FB_DIV_NOM),
  .FB_DIV_LOW  (FB_DIV_LOW),
  .FB_DIV_HIGH (FB_DIV_HIGH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .test_code (test_code),
  .lock_a    (lock_a),
  .lock_b    (lock_b),
  .fb_event  (fb_event),
  .ref1_tick (ref1_tick),
  .ref2_tick (ref2_tick),
  .fb_tick   (fb_tick),
  .test_pin  (test_pin)
);

// File: tb/tb_pll_fixdiv_testsel.sv
module tb_pll_fixdiv_testsel;
  logic       clk;
  logic       rst_n;
  logic [6:0] test_code;
  logic       lock_a, lock_b, fb_event, prog_pulse;
  logic       ref1_tick, ref2_tick, fb_tick, test_pin;

  int     checks;
  int     errors;
  longint cyc;
  logic   busy;
  logic   done;

  localparam int K_LEVEL  = 0;
  localparam int K_PERIOD = 1;
  localparam int K_FROM   = 2;
  localparam int S_REF2 = 0, S_REF1 = 1, S_FB = 2, S_PIN = 3;

  typedef struct {
    string  req;
    int     kind;
    int     sig;
    int     exp;
    int     skip;
    longint start;
  } item_t;

  item_t q[$];

  pll_fixdiv_testsel dut (
    .clk(clk), .rst_n(rst_n), .test_code(test_code),
    .lock_a(lock_a), .lock_b(lock_b), .fb_event(fb_event), .prog_pulse(prog_pulse),
    .ref1_tick(ref1_tick), .ref2_tick(ref2_tick), .fb_tick(fb_tick), .test_pin(test_pin)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic probe(input int s);
    case (s)
      S_REF2:  return ref2_tick;
      S_REF1:  return ref1_tick;
      S_FB:    return fb_tick;
      default: return test_pin;
    endcase
  endfunction

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input string req, input int kind, input int sig, input int exp,
                      input int skip, input longint start);
    item_t it;
    it.req = req; it.kind = kind; it.sig = sig; it.exp = exp; it.skip = skip; it.start = start;
    q.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk);
    while (q.size() != 0 || busy) @(negedge clk);
  endtask

  task automatic level(input string req, input logic [6:0] code, input logic a,
                       input logic b, input int exp);
    test_code = code; lock_a = a; lock_b = b;
    push(req, K_LEVEL, S_PIN, exp, 0, 0);
    settle();
  endtask

  task automatic period(input string req, input logic [6:0] code, input int sig, input int exp);
    test_code = code;
    push(req, K_PERIOD, sig, exp, 1, 0);
    settle();
  endtask

  // Switch the code just after a feedback wrap; the interval in progress keeps the old ratio.
  task automatic switch_at_wrap(input string req, input logic [6:0] code, input int old_exp);
    logic   prev;
    longint c0;
    prev = fb_tick;
    forever begin
      @(negedge clk);
      if (fb_tick && !prev) break;
      prev = fb_tick;
    end
    c0 = cyc;
    test_code = code;
    push(req, K_FROM, S_FB, old_exp, 0, c0);
    settle();
  endtask

  // Scoreboard monitor
  initial begin
    busy = 1'b0;
    forever begin
      item_t  it;
      logic   prev, cur;
      int     rises, guard, need;
      longint t0, t1;
      while (q.size() == 0) @(negedge clk);
      busy = 1'b1;
      it = q.pop_front();
      if (it.kind == K_LEVEL) begin
        repeat (3) @(negedge clk);
        check(it.req, test_pin == it.exp[0], test_pin, it.exp);
      end else begin
        need  = (it.kind == K_FROM) ? 1 : it.skip + 2;
        t0    = it.start;
        t1    = 0;
        rises = 0;
        guard = 0;
        prev  = probe(it.sig);
        while (rises < need && guard < 20000) begin
          @(negedge clk);
          guard++;
          cur = probe(it.sig);
          if (cur && !prev) begin
            rises++;
            if (it.kind != K_FROM && rises == it.skip + 1) t0 = cyc;
            if (rises == need) t1 = cyc;
          end
          prev = cur;
        end
        check(it.req, rises == need && (t1 - t0) == it.exp, t1 - t0, it.exp);
      end
      busy = 1'b0;
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Driver
  initial begin
    checks = 0; errors = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; test_code = 7'b0000000;
    lock_a = 1'b1; lock_b = 1'b1; fb_event = 1'b0; prog_pulse = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 reset pin",  test_pin  == 1'b0, test_pin,  0);
    check("R11 reset ref1", ref1_tick == 1'b0, ref1_tick, 0);
    check("R11 reset ref2", ref2_tick == 1'b0, ref2_tick, 0);
    check("R11 reset fb",   fb_tick   == 1'b0, fb_tick,   0);
    rst_n = 1'b1;
    fb_event = 1'b1; prog_pulse = 1'b1;
    repeat (5) @(negedge clk);

    period("R1 ref2 period", 7'b0000000, S_REF2, 130);
    period("R2 ref1 period", 7'b0000000, S_REF1, 4);
    period("R3 fb nominal period", 7'b0000000, S_FB, 1034);

    level("R6 lock_a high", 7'b0000000, 1'b1, 1'b0, 1);
    level("R6 lock_b ignored", 7'b0000000, 1'b0, 1'b1, 0);
    level("R7 lock_b selected", 7'b0000100, 1'b0, 1'b1, 1);
    level("R7 lock_b low", 7'b0000100, 1'b1, 1'b0, 0);
    level("R7 both locked", 7'b0000001, 1'b1, 1'b1, 1);
    level("R7 one unlocked", 7'b0000001, 1'b0, 1'b1, 0);
    level("R6 unlisted code high", 7'b1010101, 1'b1, 1'b0, 1);
    level("R6 unlisted code low", 7'b1010101, 1'b0, 1'b1, 0);
    level("R11 pin follows lock", 7'b0000000, 1'b1, 1'b1, 1);

    period("R8 prog div16", 7'b0010010, S_PIN, 16);
    period("R9 ref1 div8", 7'b0011010, S_PIN, 32);
    period("R10 fb div2", 7'b0010110, S_PIN, 2068);
    period("R10 ref2 undivided", 7'b0011110, S_PIN, 130);

    test_code = 7'b0000000;
    switch_at_wrap("R5 old ratio kept", 7'b1000000, 1034);
    push("R4 low ratio", K_PERIOD, S_FB, 987, 0, 0);
    settle();
    level("R6 ratio code shows lock_a", 7'b1000000, 1'b1, 1'b0, 1);
    switch_at_wrap("R5 low kept on change", 7'b1100000, 987);
    push("R4 high ratio", K_PERIOD, S_FB, 1081, 0, 0);
    settle();
    switch_at_wrap("R5 high kept on change", 7'b0000000, 1081);
    push("R4 nominal restored", K_PERIOD, S_FB, 1034, 0, 0);
    settle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule